// File: doc/BRIEF.md
# Dual-Channel DMA Sequencer

This block sequences descriptor-driven transfers for a receive channel and a transmit channel that share a single DMA engine. Software hands each channel a 64-bit descriptor carrying a memory address and a byte length. The channel then waits until its packet FIFO is ready and asks for the shared engine. It holds the engine for the whole transfer and finally reports completion through a status word and a one-cycle event.

Receive transfers write memory and move the smaller of the descriptor length and the waiting packet's size. Transmit transfers read memory and move the full descriptor length. The engine models transfer time as a fixed delay plus a cost for every started 64-byte block. When a transfer finishes, the other channel gets the engine first if both channels ask for it at once. A soft reset returns everything to idle and drops any transfer in flight without reporting it. The packet FIFOs and the memory are outside the block: it sees only a packet-ready flag and size for receive, and a free-space count for transmit.

Top module: `dma_dual_seq`

## Requirements
- R1: A descriptor write is accepted only while its channel is idle. When the channel is enabled, the accepted write starts the sequence. When the channel is disabled, the descriptor is stored but no transfer starts. A descriptor write made while the channel is not idle has no effect on the transfer in progress.
- R2: After accepting a descriptor, the receive channel waits until `rx_pkt_valid` is high. The transmit channel waits until `tx_fifo_free` is at least `tx_max_copy`.
- R3: A channel that is ready to copy waits while the shared engine is busy. It issues its transfer in the first cycle the engine is free. Only one transfer is active at a time.
- R4: In the descriptor, bits [15:0] hold the length and bits [63:16] hold the address. Receive transfers set `dma_wr`=1 and use the minimum of the descriptor length and the packet size. Transmit transfers set `dma_wr`=0 and use the descriptor length.
- R5: `dma_busy` stays high for exactly LAT_BASE + ceil(len/64)·LAT_PER_BLK cycles per transfer, and never fewer than 1. With the defaults, a zero-length transfer takes 4 cycles and a 130-byte transfer takes 10.
- R6: If both channels become ready for the free engine in the same cycle, the channel that did not finish the most recent transfer wins. After reset, receive wins.
- R7: On transmit completion, `tx_status` becomes bit 31 set, bit 30 clear and the length in bits [15:0]. `ev_tx_dma` and `tx_pkt_push` pulse for one cycle.
- R8: On receive completion, bit 31 of `rx_status` is set and bit 30 stays set. `ev_rx_dma` and `rx_pkt_pop` pulse for one cycle.
- R9: On transmit completion, the block computes the FIFO space left after the push as `tx_fifo_free` − len, floored at 0. If that space is below `tx_max_copy`, `ev_tx_full` pulses together with `ev_tx_dma`, and `tx_full` goes high and stays high until reset.
- R10: `soft_rst` returns both channels and the engine to idle and drops any transfer in flight with no completion event. It also clears both status words and `tx_full`, and gives receive the priority again.
- R11: Accepting a descriptor sets that channel's status to 0x4000_0000 (bit 30 marks the channel as busy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to idle |
| rx_en | input | 1 | Receive channel enable |
| tx_en | input | 1 | Transmit channel enable |
| rx_desc_wr | input | 1 | Receive descriptor write strobe |
| rx_desc_data | input | 64 | Receive descriptor {address, length} |
| tx_desc_wr | input | 1 | Transmit descriptor write strobe |
| tx_desc_data | input | 64 | Transmit descriptor {address, length} |
| rx_pkt_valid | input | 1 | Receive FIFO holds a packet |
| rx_pkt_bytes | input | 16 | Size of the waiting receive packet |
| tx_fifo_free | input | 16 | Free bytes in the transmit FIFO |
| tx_max_copy | input | 16 | Largest transmit copy, FIFO space threshold |
| dma_busy | output | 1 | Shared engine is moving data |
| dma_wr | output | 1 | 1 = memory write (receive), 0 = memory read |
| dma_addr | output | 48 | Address of current/last transfer |
| dma_len | output | 16 | Length of current/last transfer |
| rx_status | output | 32 | Receive completion status |
| tx_status | output | 32 | Transmit completion status |
| ev_rx_dma | output | 1 | Receive transfer finished (pulse) |
| ev_tx_dma | output | 1 | Transmit transfer finished (pulse) |
| ev_tx_full | output | 1 | Transmit FIFO short of space after push (pulse) |
| tx_full | output | 1 | Sticky transmit-full flag |
| rx_pkt_pop | output | 1 | Take the packet from the receive FIFO (pulse) |
| tx_pkt_push | output | 1 | Push the packet into the transmit FIFO (pulse) |

## Verification
On every cycle, the assertions check that the two channels never copy at once and that a waiting channel holds its place while the engine is busy. They also check that each completion pulse comes with the matching status bits, that the full pulse and flag agree with the transmit completion, and that soft reset leaves everything idle and silent. Other behaviour needs the bench's scenarios, which compare a behavioural model on every clock: the exact latency per length, the receive length clipping, the tie-break after each completion, and ignored descriptor writes during a transfer. The same holds for the loss of an in-flight transfer on soft reset.

// File: rtl/dds_pkg.sv
package dds_pkg;
   typedef enum logic [2:0] {
      CH_IDLE      = 3'd0,
      CH_FIFO_WAIT = 3'd1,
      CH_BEGIN     = 3'd2,
      CH_COPY      = 3'd3,
      CH_DONE      = 3'd4
   } ch_state_e;

   localparam int          STAT_W      = 32;
   localparam logic [31:0] STAT_BUSY_V = 32'h4000_0000;
   localparam logic [31:0] STAT_DONE_V = 32'h8000_0000;
endpackage

// File: rtl/dds_chan.sv
module dds_chan
   import dds_pkg::*;
#(
   parameter bit IS_RX  = 1'b1,
   parameter int ADDR_W = 48,
   parameter int LEN_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    soft_rst,
   input  logic                    en,
   input  logic                    desc_wr,
   input  logic [ADDR_W+LEN_W-1:0] desc_in,
   input  logic                    fifo_ok,
   input  logic [LEN_W-1:0]        pkt_bytes,
   input  logic [LEN_W-1:0]        fifo_free,
   input  logic [LEN_W-1:0]        max_copy,
   input  logic                    grant,
   input  logic                    done_me,
   output ch_state_e               state_o,
   output logic                    req_o,
   output logic [ADDR_W-1:0]       xfer_addr,
   output logic [LEN_W-1:0]        xfer_len,
   output logic [STAT_W-1:0]       status_o,
   output logic                    ev_dma,
   output logic                    ev_full,
   output logic                    full_flag,
   output logic                    fifo_op
);
   localparam int DESC_W = ADDR_W + LEN_W;

   ch_state_e          st;
   logic [DESC_W-1:0]  desc_q;
   logic [LEN_W-1:0]   pkt_q;
   logic [STAT_W-1:0]  stat_q;
   logic [STAT_W-1:0]  done_stat;
   logic [LEN_W-1:0]   d_len;
   logic               finish;

   assign d_len     = desc_q[LEN_W-1:0];
   assign xfer_addr = desc_q[DESC_W-1:LEN_W];
   assign finish    = (st == CH_COPY) && done_me;

   generate
      if (IS_RX) begin : g_rx
         logic unused_tx_in;
         assign unused_tx_in = ^{fifo_free, max_copy};
         assign xfer_len  = (pkt_q < d_len) ? pkt_q : d_len;
         assign done_stat = stat_q | STAT_DONE_V;
         assign ev_full   = 1'b0;
         assign full_flag = 1'b0;
      end else begin : g_tx
         logic             unused_pkt;
         logic [LEN_W-1:0] space_left;
         logic             short_space;
         logic             hit_q;
         logic             flag_q;
         assign unused_pkt  = ^pkt_q;
         assign xfer_len    = d_len;
         assign done_stat   = STAT_DONE_V | STAT_W'(xfer_len);
         assign space_left  = (fifo_free >= xfer_len) ? (fifo_free - xfer_len) : '0;
         assign short_space = space_left < max_copy;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hit_q  <= 1'b0;
               flag_q <= 1'b0;
            end else if (soft_rst) begin
               hit_q  <= 1'b0;
               flag_q <= 1'b0;
            end else if (finish) begin
               hit_q <= short_space;
               if (short_space) flag_q <= 1'b1;
            end
         end
         assign ev_full   = (st == CH_DONE) && hit_q;
         assign full_flag = flag_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= CH_IDLE;
         desc_q <= '0;
         pkt_q  <= '0;
         stat_q <= '0;
      end else if (soft_rst) begin
         st     <= CH_IDLE;
         desc_q <= '0;
         pkt_q  <= '0;
         stat_q <= '0;
      end else begin
         unique case (st)
            CH_IDLE: if (desc_wr) begin
               desc_q <= desc_in;
               stat_q <= STAT_BUSY_V;
               if (en) st <= CH_FIFO_WAIT;
            end
            CH_FIFO_WAIT: if (fifo_ok) begin
               pkt_q <= pkt_bytes;
               st    <= CH_BEGIN;
            end
            CH_BEGIN: if (grant) st <= CH_COPY;
            CH_COPY: if (done_me) begin
               stat_q <= done_stat;
               st     <= CH_DONE;
            end
            CH_DONE: st <= CH_IDLE;
            default: st <= CH_IDLE;
         endcase
      end
   end

   assign state_o  = st;
   assign req_o    = (st == CH_BEGIN);
   assign status_o = stat_q;
   assign ev_dma   = (st == CH_DONE);
   assign fifo_op  = (st == CH_DONE);
endmodule

// File: rtl/dds_arb.sv
module dds_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic rx_req,
   input  logic tx_req,
   input  logic eng_busy,
   input  logic eng_done,
   input  logic eng_owner_rx,
   output logic gnt_rx,
   output logic gnt_tx
);
   logic prefer_rx;

   assign gnt_rx = !eng_busy && rx_req && (!tx_req || prefer_rx);
   assign gnt_tx = !eng_busy && tx_req && (!rx_req || !prefer_rx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         prefer_rx <= 1'b1;
      else if (soft_rst)  prefer_rx <= 1'b1;
      else if (eng_done)  prefer_rx <= !eng_owner_rx;
   end
endmodule

// File: rtl/dds_engine.sv
module dds_engine #(
   parameter int ADDR_W      = 48,
   parameter int LEN_W       = 16,
   parameter int LAT_BASE    = 4,
   parameter int LAT_PER_BLK = 2,
   parameter int BLK_SHIFT   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              start,
   input  logic              start_rx,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  start_len,
   output logic              busy,
   output logic              done,
   output logic              owner_rx,
   output logic [ADDR_W-1:0] addr,
   output logic [LEN_W-1:0]  len,
   output logic              wr
);
   localparam int MAX_BLK  = ((1 << LEN_W) - 1 + (1 << BLK_SHIFT) - 1) >> BLK_SHIFT;
   localparam int MAX_LAT  = LAT_BASE + MAX_BLK * LAT_PER_BLK + 1;
   localparam int CNT_W    = $clog2(MAX_LAT + 1);
   localparam int BLK_MASK = (1 << BLK_SHIFT) - 1;

   logic [LEN_W:0]   blk_sum;
   logic [LEN_W:0]   blocks;
   logic [CNT_W-1:0] lat_raw;
   logic [CNT_W-1:0] lat;
   logic [CNT_W-1:0] cnt;

   assign blk_sum = {1'b0, start_len} + (LEN_W+1)'(BLK_MASK);
   assign blocks  = blk_sum >> BLK_SHIFT;
   assign lat_raw = CNT_W'(LAT_BASE) + CNT_W'(blocks) * CNT_W'(LAT_PER_BLK);
   assign lat     = (lat_raw == '0) ? CNT_W'(1) : lat_raw;
   assign done    = busy && (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; cnt <= '0; owner_rx <= 1'b0;
         addr <= '0;   len <= '0; wr <= 1'b0;
      end else if (soft_rst) begin
         busy <= 1'b0; cnt <= '0; owner_rx <= 1'b0;
         addr <= '0;   len <= '0; wr <= 1'b0;
      end else if (start) begin
         busy     <= 1'b1;
         cnt      <= lat;
         owner_rx <= start_rx;
         wr       <= start_rx;
         addr     <= start_addr;
         len      <= start_len;
      end else if (busy) begin
         if (done) busy <= 1'b0;
         else      cnt  <= cnt - CNT_W'(1);
      end
   end
endmodule

// File: rtl/dma_dual_seq.sv
module dma_dual_seq
   import dds_pkg::*;
#(
   parameter int ADDR_W      = 48,
   parameter int LEN_W       = 16,
   parameter int LAT_BASE    = 4,
   parameter int LAT_PER_BLK = 2,
   parameter int BLK_SHIFT   = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    soft_rst,
   input  logic                    rx_en,
   input  logic                    tx_en,
   input  logic                    rx_desc_wr,
   input  logic [ADDR_W+LEN_W-1:0] rx_desc_data,
   input  logic                    tx_desc_wr,
   input  logic [ADDR_W+LEN_W-1:0] tx_desc_data,
   input  logic                    rx_pkt_valid,
   input  logic [LEN_W-1:0]        rx_pkt_bytes,
   input  logic [LEN_W-1:0]        tx_fifo_free,
   input  logic [LEN_W-1:0]        tx_max_copy,
   output logic                    dma_busy,
   output logic                    dma_wr,
   output logic [ADDR_W-1:0]       dma_addr,
   output logic [LEN_W-1:0]        dma_len,
   output logic [STAT_W-1:0]       rx_status,
   output logic [STAT_W-1:0]       tx_status,
   output logic                    ev_rx_dma,
   output logic                    ev_tx_dma,
   output logic                    ev_tx_full,
   output logic                    tx_full,
   output logic                    rx_pkt_pop,
   output logic                    tx_pkt_push
);
   generate
      if (ADDR_W + LEN_W != 64) begin : g_bad_desc
         $error("descriptor must be 64 bits wide");
      end
      if (LEN_W > STAT_W - 2) begin : g_bad_len
         $error("length field collides with status flags");
      end
      if (BLK_SHIFT >= LEN_W || BLK_SHIFT < 1) begin : g_bad_blk
         $error("block size out of range");
      end
   endgenerate

   ch_state_e         rx_st, tx_st;
   logic              rx_req, tx_req, gnt_rx, gnt_tx;
   logic              eng_done, eng_owner_rx;
   logic [ADDR_W-1:0] rx_addr, tx_addr;
   logic [LEN_W-1:0]  rx_len, tx_len;
   logic              rx_ev_full_unused, rx_full_unused;

   dds_chan #(.IS_RX(1'b1), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .en(rx_en),
      .desc_wr(rx_desc_wr), .desc_in(rx_desc_data),
      .fifo_ok(rx_pkt_valid), .pkt_bytes(rx_pkt_bytes),
      .fifo_free('0), .max_copy('0),
      .grant(gnt_rx), .done_me(eng_done && eng_owner_rx),
      .state_o(rx_st), .req_o(rx_req), .xfer_addr(rx_addr), .xfer_len(rx_len),
      .status_o(rx_status), .ev_dma(ev_rx_dma), .ev_full(rx_ev_full_unused),
      .full_flag(rx_full_unused), .fifo_op(rx_pkt_pop)
   );

   dds_chan #(.IS_RX(1'b0), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .en(tx_en),
      .desc_wr(tx_desc_wr), .desc_in(tx_desc_data),
      .fifo_ok(tx_fifo_free >= tx_max_copy), .pkt_bytes('0),
      .fifo_free(tx_fifo_free), .max_copy(tx_max_copy),
      .grant(gnt_tx), .done_me(eng_done && !eng_owner_rx),
      .state_o(tx_st), .req_o(tx_req), .xfer_addr(tx_addr), .xfer_len(tx_len),
      .status_o(tx_status), .ev_dma(ev_tx_dma), .ev_full(ev_tx_full),
      .full_flag(tx_full), .fifo_op(tx_pkt_push)
   );

   dds_arb u_arb (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .rx_req(rx_req), .tx_req(tx_req), .eng_busy(dma_busy),
      .eng_done(eng_done), .eng_owner_rx(eng_owner_rx),
      .gnt_rx(gnt_rx), .gnt_tx(gnt_tx)
   );

   dds_engine #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LAT_BASE(LAT_BASE),
      .LAT_PER_BLK(LAT_PER_BLK), .BLK_SHIFT(BLK_SHIFT)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .start(gnt_rx || gnt_tx), .start_rx(gnt_rx),
      .start_addr(gnt_rx ? rx_addr : tx_addr),
      .start_len(gnt_rx ? rx_len : tx_len),
      .busy(dma_busy), .done(eng_done), .owner_rx(eng_owner_rx),
      .addr(dma_addr), .len(dma_len), .wr(dma_wr)
   );
endmodule

// File: rtl/dma_dual_seq_chk.sv
module dma_dual_seq_chk
   import dds_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        soft_rst,
   input ch_state_e   rx_st,
   input ch_state_e   tx_st,
   input logic        dma_busy,
   input logic        dma_wr,
   input logic [31:0] rx_status,
   input logic [31:0] tx_status,
   input logic        ev_rx_dma,
   input logic        ev_tx_dma,
   input logic        ev_tx_full,
   input logic        tx_full
);
   AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_st == CH_COPY && tx_st == CH_COPY));  // R3
   AST_RX_COPY_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_st == CH_COPY) |-> (dma_busy && dma_wr));  // R4
   AST_TX_COPY_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_st == CH_COPY) |-> (dma_busy && !dma_wr));  // R4
   AST_RX_BEGIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_st == CH_BEGIN && dma_busy && !soft_rst) |=> (rx_st == CH_BEGIN));  // R3
   AST_TX_BEGIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_st == CH_BEGIN && dma_busy && !soft_rst) |=> (tx_st == CH_BEGIN));  // R3
   AST_TX_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx_dma |-> (tx_status[31] && !tx_status[30]));  // R7
   AST_TX_EVENT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx_dma |=> !ev_tx_dma);  // R7
   AST_RX_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_dma |-> (rx_status[31] && rx_status[30]));  // R8
   AST_FULL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx_full |-> (ev_tx_dma && tx_full));  // R9
   AST_FULL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_full) |-> ev_tx_full);  // R9
   AST_SOFT_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (rx_st == CH_IDLE && tx_st == CH_IDLE && !dma_busy
                    && !ev_rx_dma && !ev_tx_dma && !tx_full));  // R10
endmodule

bind dma_dual_seq dma_dual_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
   .rx_st(rx_st), .tx_st(tx_st), .dma_busy(dma_busy), .dma_wr(dma_wr),
   .rx_status(rx_status), .tx_status(tx_status),
   .ev_rx_dma(ev_rx_dma), .ev_tx_dma(ev_tx_dma),
   .ev_tx_full(ev_tx_full), .tx_full(tx_full)
);

// File: tb/dma_dual_seq_tb.sv
module dma_dual_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        rx_en = 1'b0, tx_en = 1'b0;
   logic        rx_desc_wr = 1'b0, tx_desc_wr = 1'b0;
   logic [63:0] rx_desc_data = '0, tx_desc_data = '0;
   logic        rx_pkt_valid = 1'b0;
   logic [15:0] rx_pkt_bytes = '0, tx_fifo_free = '0, tx_max_copy = '0;
   logic        dma_busy, dma_wr;
   logic [47:0] dma_addr;
   logic [15:0] dma_len;
   logic [31:0] rx_status, tx_status;
   logic        ev_rx_dma, ev_tx_dma, ev_tx_full, tx_full, rx_pkt_pop, tx_pkt_push;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_dual_seq u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_en(rx_en), .tx_en(tx_en),
      .rx_desc_wr(rx_desc_wr), .rx_desc_data(rx_desc_data),
      .tx_desc_wr(tx_desc_wr), .tx_desc_data(tx_desc_data),
      .rx_pkt_valid(rx_pkt_valid), .rx_pkt_bytes(rx_pkt_bytes),
      .tx_fifo_free(tx_fifo_free), .tx_max_copy(tx_max_copy),
      .dma_busy(dma_busy), .dma_wr(dma_wr), .dma_addr(dma_addr), .dma_len(dma_len),
      .rx_status(rx_status), .tx_status(tx_status),
      .ev_rx_dma(ev_rx_dma), .ev_tx_dma(ev_tx_dma), .ev_tx_full(ev_tx_full),
      .tx_full(tx_full), .rx_pkt_pop(rx_pkt_pop), .tx_pkt_push(tx_pkt_push)
   );

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          m_rxs, m_txs, m_cnt;   // 0 idle 1 wait 2 begin 3 copy 4 done
   logic [63:0] m_rxd, m_txd;
   logic [15:0] m_rxpkt, m_len;
   logic [47:0] m_addr;
   logic        m_busy, m_wr, m_own_rx, m_pref_rx, m_full, m_fhit;
   logic [31:0] m_rxst, m_txst;

   function automatic int lat_of(int n);
      int b = (n + 63) / 64;
      int l = 4 + b * 2;
      return (l < 1) ? 1 : l;
   endfunction

   task automatic model_clear();
      m_rxs = 0; m_txs = 0; m_cnt = 0; m_rxd = '0; m_txd = '0; m_rxpkt = '0;
      m_len = '0; m_addr = '0; m_busy = 0; m_wr = 0; m_own_rx = 0;
      m_pref_rx = 1; m_full = 0; m_fhit = 0; m_rxst = '0; m_txst = '0;
   endtask

   always @(posedge clk) begin : model
      logic        d;
      int          g;
      int          ln, fr;
      logic [15:0] rl;
      cyc++;
      if (!rst_n || soft_rst) model_clear();
      else begin
         d = m_busy && (m_cnt == 1);
         g = 0;
         if (!m_busy) begin
            if (m_rxs == 2 && (m_txs != 2 || m_pref_rx)) g = 1;
            else if (m_txs == 2) g = 2;
         end
         case (m_rxs)
            0: if (rx_desc_wr) begin
                  m_rxd = rx_desc_data; m_rxst = 32'h4000_0000;
                  if (rx_en) m_rxs = 1;
               end
            1: if (rx_pkt_valid) begin m_rxpkt = rx_pkt_bytes; m_rxs = 2; end
            2: if (g == 1) m_rxs = 3;
            3: if (d && m_own_rx) begin m_rxst = m_rxst | 32'h8000_0000; m_rxs = 4; end
            default: m_rxs = 0;
         endcase
         case (m_txs)
            0: if (tx_desc_wr) begin
                  m_txd = tx_desc_data; m_txst = 32'h4000_0000;
                  if (tx_en) m_txs = 1;
               end
            1: if (tx_fifo_free >= tx_max_copy) m_txs = 2;
            2: if (g == 2) m_txs = 3;
            3: if (d && !m_own_rx) begin
                  ln = int'(m_txd[15:0]);
                  m_txst = 32'h8000_0000 | 32'(ln);
                  fr = (int'(tx_fifo_free) >= ln) ? int'(tx_fifo_free) - ln : 0;
                  m_fhit = (fr < int'(tx_max_copy));
                  if (m_fhit) m_full = 1;
                  m_txs = 4;
               end
            default: m_txs = 0;
         endcase
         if (d) m_pref_rx = !m_own_rx;
         if (m_busy) begin
            if (m_cnt == 1) m_busy = 0;
            else m_cnt = m_cnt - 1;
         end
         if (g == 1) begin
            rl = (m_rxpkt < m_rxd[15:0]) ? m_rxpkt : m_rxd[15:0];
            m_busy = 1; m_own_rx = 1; m_wr = 1; m_addr = m_rxd[63:16];
            m_len = rl; m_cnt = lat_of(int'(rl));
         end else if (g == 2) begin
            m_busy = 1; m_own_rx = 0; m_wr = 0; m_addr = m_txd[63:16];
            m_len = m_txd[15:0]; m_cnt = lat_of(int'(m_txd[15:0]));
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check("R3 model dma_busy", 64'(dma_busy), 64'(m_busy));
         check("R4 model dma_wr", 64'(dma_wr), 64'(m_wr));
         check("R4 model dma_addr", 64'(dma_addr), 64'(m_addr));
         check("R4 model dma_len", 64'(dma_len), 64'(m_len));
         check("R8 model rx_status", 64'(rx_status), 64'(m_rxst));
         check("R7 model tx_status", 64'(tx_status), 64'(m_txst));
         check("R8 model ev_rx_dma", 64'(ev_rx_dma), 64'(m_rxs == 4));
         check("R8 model rx_pkt_pop", 64'(rx_pkt_pop), 64'(m_rxs == 4));
         check("R7 model ev_tx_dma", 64'(ev_tx_dma), 64'(m_txs == 4));
         check("R7 model tx_pkt_push", 64'(tx_pkt_push), 64'(m_txs == 4));
         check("R9 model ev_tx_full", 64'(ev_tx_full), 64'(m_txs == 4 && m_fhit));
         check("R9 model tx_full", 64'(tx_full), 64'(m_full));
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic sel(int k);
      case (k)
         0: return dma_busy;
         1: return ev_rx_dma;
         default: return ev_tx_dma;
      endcase
   endfunction

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_sig(int k, string tag);
      int n = 0;
      while (!sel(k) && n < 400) begin @(negedge clk); n++; end
      check(tag, 64'(sel(k)), 64'd1);
   endtask

   task automatic measure(int exp, string tag);
      int n = 0;
      wait_sig(0, tag);
      while (dma_busy && n < 5000) begin n++; @(negedge clk); end
      check(tag, 64'(n), 64'(exp));
   endtask

   task automatic put_rx(logic [47:0] a, logic [15:0] l);
      rx_desc_wr = 1; rx_desc_data = {a, l};
      @(negedge clk);
      rx_desc_wr = 0;
   endtask

   task automatic put_tx(logic [47:0] a, logic [15:0] l);
      tx_desc_wr = 1; tx_desc_data = {a, l};
      @(negedge clk);
      tx_desc_wr = 0;
   endtask

   task automatic put_both(logic [47:0] ra, logic [15:0] rl, logic [47:0] ta, logic [15:0] tl);
      rx_desc_wr = 1; rx_desc_data = {ra, rl};
      tx_desc_wr = 1; tx_desc_data = {ta, tl};
      @(negedge clk);
      rx_desc_wr = 0; tx_desc_wr = 0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc == WATCHDOG) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         finish_run();
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      ticks(4);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 reset rx_status", 64'(rx_status), 64'd0);
      check("R10 reset tx_status", 64'(tx_status), 64'd0);
      check("R10 reset dma_busy", 64'(dma_busy), 64'd0);
      check("R10 reset tx_full", 64'(tx_full), 64'd0);

      // transmit alone, 130 bytes -> 3 blocks -> 10 cycles
      tx_en = 1; rx_en = 1; tx_max_copy = 16'd100; tx_fifo_free = 16'd500;
      put_tx(48'h1000, 16'd130);
      check("R11 tx busy status", 64'(tx_status), 64'h4000_0000);
      wait_sig(0, "R3 tx issue");
      check("R4 tx direction", 64'(dma_wr), 64'd0);
      check("R4 tx addr", 64'(dma_addr), 64'h1000);
      check("R4 tx len", 64'(dma_len), 64'd130);
      measure(10, "R5 latency 130 bytes");
      check("R7 tx event", 64'(ev_tx_dma), 64'd1);
      check("R7 tx status", 64'(tx_status), 64'h8000_0082);
      check("R7 tx push", 64'(tx_pkt_push), 64'd1);
      check("R9 no full", 64'(ev_tx_full), 64'd0);
      @(negedge clk);
      check("R7 tx event one cycle", 64'(ev_tx_dma), 64'd0);

      // receive waits for a packet, then clips length
      put_rx(48'h2000, 16'd200);
      ticks(8);
      check("R2 rx waits for packet", 64'(dma_busy), 64'd0);
      rx_pkt_valid = 1; rx_pkt_bytes = 16'd40;
      wait_sig(0, "R2 rx issue");
      check("R4 rx direction", 64'(dma_wr), 64'd1);
      check("R4 rx clipped len", 64'(dma_len), 64'd40);
      wait_sig(1, "R8 rx event");
      check("R8 rx status", 64'(rx_status), 64'hC000_0000);
      check("R8 rx pop", 64'(rx_pkt_pop), 64'd1);

      // transmit waits for FIFO space
      tx_fifo_free = 16'd50;
      put_tx(48'h3000, 16'd16);
      ticks(8);
      check("R2 tx waits for space", 64'(dma_busy), 64'd0);
      tx_fifo_free = 16'd500;
      wait_sig(2, "R2 tx resumes");
      ticks(2);

      // contention: tx waits behind a long rx transfer
      rx_pkt_bytes = 16'd1000;
      put_rx(48'h4000, 16'd640);
      wait_sig(0, "R3 rx long issue");
      put_tx(48'h5000, 16'd64);
      ticks(5);
      check("R3 tx held while engine busy", 64'(dma_wr), 64'd1);
      wait_sig(1, "R3 rx long done");
      measure(6, "R5 latency 64 bytes");
      check("R3 tx got engine", 64'(dma_len), 64'd64);
      check("R3 tx completes", 64'(ev_tx_dma), 64'd1);
      ticks(2);

      // simultaneous requests: last completion was transmit -> receive first
      rx_pkt_bytes = 16'd100;
      put_both(48'h6000, 16'd32, 48'h7000, 16'd32);
      wait_sig(0, "R6 tie issue");
      check("R6 rx wins after tx finished", 64'(dma_wr), 64'd1);
      wait_sig(2, "R6 tie tx done");
      ticks(2);
      put_rx(48'h8000, 16'd8);
      wait_sig(1, "R6 rx alone done");
      ticks(2);
      put_both(48'h9000, 16'd32, 48'hA000, 16'd32);
      wait_sig(0, "R6 tie issue 2");
      check("R6 tx wins after rx finished", 64'(dma_wr), 64'd0);
      wait_sig(1, "R6 tie rx done");
      ticks(2);

      // FIFO short of space after the push
      tx_fifo_free = 16'd150;
      put_tx(48'hB000, 16'd100);
      wait_sig(2, "R9 tx done");
      check("R9 full event", 64'(ev_tx_full), 64'd1);
      @(negedge clk);
      check("R9 full flag sticky", 64'(tx_full), 64'd1);
      tx_fifo_free = 16'd500;
      ticks(2);

      // soft reset abandons a transfer in flight
      rx_pkt_bytes = 16'd1000;
      put_rx(48'hC000, 16'd640);
      wait_sig(0, "R10 issue before soft reset");
      ticks(3);
      soft_rst = 1; @(negedge clk); soft_rst = 0;
      check("R10 engine idle", 64'(dma_busy), 64'd0);
      check("R10 status cleared", 64'(rx_status), 64'd0);
      check("R10 full cleared", 64'(tx_full), 64'd0);
      begin
         int seen = 0;
         for (int i = 0; i < 40; i++) begin
            if (ev_rx_dma) seen++;
            @(negedge clk);
         end
         check("R10 no completion after soft reset", 64'(seen), 64'd0);
      end

      // disabled channel stores but does not start
      rx_en = 0;
      put_rx(48'hD000, 16'd16);
      check("R1 disabled busy status", 64'(rx_status), 64'h4000_0000);
      ticks(15);
      check("R1 disabled no transfer", 64'(dma_busy), 64'd0);
      rx_en = 1;

      // write during a transfer is ignored
      put_rx(48'hE000, 16'd640);
      wait_sig(0, "R1 first issue");
      put_rx(48'hF000, 16'd8);
      ticks(4);
      check("R1 addr kept", 64'(dma_addr), 64'hE000);
      check("R1 len kept", 64'(dma_len), 64'd640);
      wait_sig(1, "R1 original completes");
      ticks(6);
      check("R1 no second transfer", 64'(dma_busy), 64'd0);

      // zero length: base latency only
      put_tx(48'h1_0000, 16'd0);
      measure(4, "R5 latency zero length");
      check("R7 zero length status", 64'(tx_status), 64'h8000_0000);
      ticks(3);
      finish_run();
   end
endmodule